// File: doc/BRIEF.md
# Byte-Stream Block Loader Controller

This controller joins a byte-wide serial receiver to a block cipher core and to a byte-wide transmitter. It takes a session of bytes from the receiver. The first bytes fill a 64-bit data block. After a short wait state it takes further bytes for an 80-bit key. It then starts the cipher, waits for the cipher to finish, and returns the 64-bit result to the transmitter as a sequence of bytes.

Each received byte is first held in an 8-bit staging register. It is then moved into the wide block or key register one bit per clock over eight cycles, most significant bit first. Bytes arrive most significant first, so the first byte of a session ends up in the top eight bits of its register. The block and key registers drive the cipher directly and hold their value while the cipher runs. A session ends after the eighth result byte. The controller then returns to idle and clears its counters and registers at the start of the next session, so the first session after reset behaves exactly like every later one.

Top module: `byte_block_loader`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is applied and right after it is released, `rx_ack`, `cph_start` and `tx_valid` are 0.
- R2: The controller takes a byte only when `rx_valid` is 1. While `rx_valid` stays 0, `rx_ack` stays 0, and `rx_ack` is never 1 in a cycle where `rx_valid` is 0.
- R3: Each byte taken produces exactly one `rx_ack` cycle. That is the cycle in which `rx_byte` is captured.
- R4: Moving one byte into its wide register takes eight single-bit shift cycles plus one count-check cycle. With `rx_valid` held high, two block bytes are therefore acknowledged 11 cycles apart, and successive acknowledges are never closer than 9 cycles.
- R5: Exactly 8 bytes fill the block. The first byte received lands in `cph_text[63:56]` and the eighth in `cph_text[7:0]`.
- R6: After the eighth block byte the controller passes through a counter-preparation state and a key-wait state. The gap from the last block acknowledge to the first key acknowledge is therefore 12 cycles.
- R7: Exactly 10 bytes fill the key. The first key byte lands in `cph_key[79:72]` and the tenth in `cph_key[7:0]`.
- R8: `cph_start` is a one-cycle pulse, issued once per session after the tenth key byte. `cph_text` and `cph_key` hold their values until `cph_done` arrives.
- R9: When `cph_done` is 1, `cph_result` is captured. It is then offered as 8 bytes, `cph_result[63:56]` first. Each byte is held on `tx_byte` with `tx_valid` = 1 until `tx_ready` = 1.
- R10: After the eighth result byte is accepted, `tx_valid` drops and the controller returns to idle. A new session then gives correct results. The first session after reset is as correct as later ones.
- R11: `rx_ack` is never 1 while `tx_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all other inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receiver has a byte available |
| rx_byte | input | 8 | Received byte |
| rx_ack | output | 1 | Byte taken by the controller |
| cph_start | output | 1 | One-cycle start pulse to the cipher |
| cph_text | output | 64 | Assembled data block |
| cph_key | output | 80 | Assembled key |
| cph_done | input | 1 | Cipher result valid |
| cph_result | input | 64 | Cipher result block |
| tx_valid | output | 1 | Result byte offered to the transmitter |
| tx_byte | output | 8 | Result byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |

## Verification
Sessions use three data patterns: ascending byte values, alternating all-ones and all-zero bytes, and a distinct pseudo-random pattern. Ascending bytes show whether the byte order or the bit order inside a byte is reversed. The alternating pattern shows stuck or swapped bits. Consecutive sessions with different data show whether leftover state from an earlier session leaks into a later one. One session holds `tx_ready` low for several cycles before each byte, to test that the offered byte is held. Acknowledge spacing is measured in cycles, which tells the eight-shift transfer and the key wait state apart from shorter or longer paths.

// File: rtl/loader_pkg.sv
package loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_TXT,
        ST_MV_TXT,
        ST_CHK_TXT,
        ST_WAIT_TXT,
        ST_PREP_KEY,
        ST_WAIT_KEY,
        ST_RD_KEY,
        ST_MV_KEY,
        ST_CHK_KEY,
        ST_PREP_RUN,
        ST_START,
        ST_BUSY,
        ST_SEND,
        ST_PREP_NEXT
    } ld_state_t;

endpackage

// File: rtl/loader_shreg.sv
// Wide serial-in register: one new bit enters at the LSB per shift.
module loader_shreg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr)
            q_d = '0;
        else if (shift_en)
            q_d = {q_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_q <= '0;
        else
            q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/loader_outreg.sv
// Parallel-load result register, emptied one byte at a time from the top.
module loader_outreg #(
    parameter int W  = 64,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [W-1:0]  din,
    input  logic          shift,
    output logic [BW-1:0] top
);
    logic [W-1:0] r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr)
            r_d = '0;
        else if (load)
            r_d = din;
        else if (shift)
            r_d = {r_q[W-BW-1:0], {BW{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign top = r_q[W-1 -: BW];
endmodule

// File: rtl/loader_fsm.sv
// Session sequencer: byte intake, bit-serial transfer, cipher run, byte output.
module loader_fsm
    import loader_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int TXT_BYTES = 8,
    parameter int KEY_BYTES = 10,
    parameter int OUT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cph_done,
    input  logic              tx_ready,
    output logic              rx_ack,
    output logic              sess_clr,
    output logic              txt_shift,
    output logic              key_shift,
    output logic              ser_bit,
    output logic              cph_start,
    output logic              out_load,
    output logic              out_shift,
    output logic              tx_valid
);
    localparam int MAXB = (KEY_BYTES > TXT_BYTES)
                          ? ((KEY_BYTES > OUT_BYTES) ? KEY_BYTES : OUT_BYTES)
                          : ((TXT_BYTES > OUT_BYTES) ? TXT_BYTES : OUT_BYTES);
    localparam int CW  = $clog2(MAXB + 1);
    localparam int BCW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0]  TXT_LAST = CW'(TXT_BYTES - 1);
    localparam logic [CW-1:0]  KEY_LAST = CW'(KEY_BYTES - 1);
    localparam logic [CW-1:0]  OUT_LAST = CW'(OUT_BYTES - 1);
    localparam logic [BCW-1:0] BIT_LAST = BCW'(BYTE_W - 1);

    typedef struct packed {
        ld_state_t         st;
        logic [CW-1:0]     nbytes;
        logic [BCW-1:0]    nbits;
        logic [BYTE_W-1:0] stage;
    } fsm_reg_t;

    fsm_reg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.nbytes = '0;
                s_d.nbits  = '0;
                s_d.stage  = '0;
                if (rx_valid) s_d.st = ST_RD_TXT;
            end
            ST_WAIT_TXT: begin
                if (rx_valid) s_d.st = ST_RD_TXT;
            end
            ST_RD_TXT: begin
                s_d.stage = rx_byte;
                s_d.nbits = '0;
                s_d.st    = ST_MV_TXT;
            end
            ST_MV_TXT: begin
                s_d.stage = {s_q.stage[BYTE_W-2:0], 1'b0};
                s_d.nbits = s_q.nbits + 1'b1;
                if (s_q.nbits == BIT_LAST) s_d.st = ST_CHK_TXT;
            end
            ST_CHK_TXT: begin
                s_d.nbytes = s_q.nbytes + 1'b1;
                s_d.st     = (s_q.nbytes == TXT_LAST) ? ST_PREP_KEY : ST_WAIT_TXT;
            end
            ST_PREP_KEY: begin
                s_d.nbytes = '0;
                s_d.st     = ST_WAIT_KEY;
            end
            ST_WAIT_KEY: begin
                if (rx_valid) s_d.st = ST_RD_KEY;
            end
            ST_RD_KEY: begin
                s_d.stage = rx_byte;
                s_d.nbits = '0;
                s_d.st    = ST_MV_KEY;
            end
            ST_MV_KEY: begin
                s_d.stage = {s_q.stage[BYTE_W-2:0], 1'b0};
                s_d.nbits = s_q.nbits + 1'b1;
                if (s_q.nbits == BIT_LAST) s_d.st = ST_CHK_KEY;
            end
            ST_CHK_KEY: begin
                s_d.nbytes = s_q.nbytes + 1'b1;
                s_d.st     = (s_q.nbytes == KEY_LAST) ? ST_PREP_RUN : ST_WAIT_KEY;
            end
            ST_PREP_RUN: begin
                s_d.nbytes = '0;
                s_d.st     = ST_START;
            end
            ST_START: begin
                s_d.st = ST_BUSY;
            end
            ST_BUSY: begin
                if (cph_done) begin
                    s_d.nbytes = '0;
                    s_d.st     = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    s_d.nbytes = s_q.nbytes + 1'b1;
                    if (s_q.nbytes == OUT_LAST) s_d.st = ST_PREP_NEXT;
                end
            end
            ST_PREP_NEXT: begin
                s_d.nbytes = '0;
                s_d.st     = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.nbytes <= '0;
            s_q.nbits  <= '0;
            s_q.stage  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_ack    = (s_q.st == ST_RD_TXT) || (s_q.st == ST_RD_KEY);
    assign sess_clr  = (s_q.st == ST_IDLE);
    assign txt_shift = (s_q.st == ST_MV_TXT);
    assign key_shift = (s_q.st == ST_MV_KEY);
    assign ser_bit   = s_q.stage[BYTE_W-1];
    assign cph_start = (s_q.st == ST_START);
    assign out_load  = (s_q.st == ST_BUSY) && cph_done;
    assign out_shift = (s_q.st == ST_SEND) && tx_ready;
    assign tx_valid  = (s_q.st == ST_SEND);
endmodule

// File: rtl/byte_block_loader.sv
module byte_block_loader #(
    parameter int BYTE_W = 8,
    parameter int TXT_W  = 64,
    parameter int KEY_W  = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ack,
    output logic              cph_start,
    output logic [TXT_W-1:0]  cph_text,
    output logic [KEY_W-1:0]  cph_key,
    input  logic              cph_done,
    input  logic [TXT_W-1:0]  cph_result,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_ready
);
    localparam int TXT_BYTES = TXT_W / BYTE_W;
    localparam int KEY_BYTES = KEY_W / BYTE_W;
    localparam int OUT_BYTES = TXT_W / BYTE_W;

    logic sess_clr, txt_shift, key_shift, ser_bit, out_load, out_shift;

    loader_fsm #(
        .BYTE_W   (BYTE_W),
        .TXT_BYTES(TXT_BYTES),
        .KEY_BYTES(KEY_BYTES),
        .OUT_BYTES(OUT_BYTES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cph_done (cph_done),
        .tx_ready (tx_ready),
        .rx_ack   (rx_ack),
        .sess_clr (sess_clr),
        .txt_shift(txt_shift),
        .key_shift(key_shift),
        .ser_bit  (ser_bit),
        .cph_start(cph_start),
        .out_load (out_load),
        .out_shift(out_shift),
        .tx_valid (tx_valid)
    );

    loader_shreg #(.W(TXT_W)) u_txt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sess_clr),
        .shift_en(txt_shift),
        .bit_in  (ser_bit),
        .q       (cph_text)
    );

    loader_shreg #(.W(KEY_W)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sess_clr),
        .shift_en(key_shift),
        .bit_in  (ser_bit),
        .q       (cph_key)
    );

    loader_outreg #(.W(TXT_W), .BW(BYTE_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sess_clr),
        .load (out_load),
        .din  (cph_result),
        .shift(out_shift),
        .top  (tx_byte)
    );
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
    parameter int BYTE_W = 8,
    parameter int TXT_W  = 64,
    parameter int KEY_W  = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ack,
    input logic              cph_start,
    input logic [TXT_W-1:0]  cph_text,
    input logic [KEY_W-1:0]  cph_key,
    input logic              cph_done,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_ready
);
    localparam int GW = 8;
    logic [GW-1:0] gap_q;
    logic          seen_q;
    logic          run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (rx_ack) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != {GW{1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
            if (cph_start) run_q <= 1'b1;
            else if (cph_done) run_q <= 1'b0;
        end
    end

    p_ack_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> rx_valid);

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_ack);

    p_ack_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && seen_q) |-> (gap_q >= GW'(BYTE_W)));

    p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cph_start |=> !cph_start);

    p_operands_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !cph_done && !cph_start) |=> ($stable(cph_text) && $stable(cph_key)));

    p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    p_no_ack_in_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ack);
endmodule

bind byte_block_loader loader_checker #(
    .BYTE_W(BYTE_W), .TXT_W(TXT_W), .KEY_W(KEY_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ack   (rx_ack),
    .cph_start(cph_start),
    .cph_text (cph_text),
    .cph_key  (cph_key),
    .cph_done (cph_done),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .tx_ready (tx_ready)
);

// File: tb/tb_byte_block_loader.sv
`timescale 1ns/1ps
module tb_byte_block_loader;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ack;
    logic        cph_start;
    logic [63:0] cph_text;
    logic [79:0] cph_key;
    logic        cph_done = 1'b0;
    logic [63:0] cph_result = '0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    byte_block_loader dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ack(rx_ack), .cph_start(cph_start), .cph_text(cph_text),
        .cph_key(cph_key), .cph_done(cph_done), .cph_result(cph_result),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    function automatic logic [63:0] model_cipher(input logic [63:0] t, input logic [79:0] k);
        return t ^ k[79:16] ^ 64'h5A3C_96E1_0F87_D24B;
    endfunction

    // Offers one byte and returns the cycle number at which it was acknowledged.
    task automatic send_byte(input logic [7:0] b, output int ack_cyc);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        while (!rx_ack) @(negedge clk);
        ack_cyc = cyc;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rx_ack == 0 && cph_start == 0 && tx_valid == 0, "R1 in reset",
              {rx_ack, cph_start, tx_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_ack == 0 && cph_start == 0 && tx_valid == 0, "R1 after release",
              {rx_ack, cph_start, tx_valid}, 0);
    endtask

    task automatic t_idle_quiet();
        bit any = 0;
        rx_byte = 8'hFF;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rx_ack || cph_start || tx_valid) any = 1;
        end
        check(!any, "R2 idle without rx_valid", any, 0);
    endtask

    task automatic t_session(input logic [63:0] txt, input logic [79:0] key,
                             input int stall, input string tag);
        int a_prev, a_now;
        logic [63:0] res;
        bit hold_ok;
        bit gap_ok = 1;
        int wait_cnt;
        // R5: block bytes, most significant first; R4 spacing
        for (int i = 0; i < 8; i++) begin
            send_byte(txt[63-8*i -: 8], a_now);
            if (i > 0 && (a_now - a_prev) != 11) gap_ok = 0;
            a_prev = a_now;
        end
        check(gap_ok, {"R4 block byte spacing ", tag}, a_now - a_prev, 11);
        // R6: first key byte after wait state
        for (int i = 0; i < 10; i++) begin
            send_byte(key[79-8*i -: 8], a_now);
            if (i == 0)
                check((a_now - a_prev) == 12, {"R6 key wait gap ", tag}, a_now - a_prev, 12);
            a_prev = a_now;
        end
        // R8: start pulse
        wait_cnt = 0;
        while (!cph_start && wait_cnt < 50) begin @(negedge clk); wait_cnt++; end
        check(cph_start == 1, {"R8 start issued ", tag}, cph_start, 1);
        check(cph_text == txt, {"R5 block assembled ", tag}, cph_text, txt);
        check(cph_key == key, {"R7 key assembled ", tag}, cph_key, key);
        @(negedge clk);
        check(cph_start == 0, {"R8 start is one cycle ", tag}, cph_start, 0);
        repeat (5) @(negedge clk);
        check(cph_text == txt && cph_key == key, {"R8 operands held ", tag},
              {cph_text, cph_key}, {txt, key});
        res = model_cipher(txt, key);
        cph_result = res;
        cph_done   = 1'b1;
        @(negedge clk);
        cph_done   = 1'b0;
        cph_result = '0;
        // R9: result bytes
        for (int i = 0; i < 8; i++) begin
            check(tx_valid == 1, {"R9 tx_valid ", tag}, tx_valid, 1);
            check(tx_byte == res[63-8*i -: 8], {"R9 tx byte ", tag},
                  tx_byte, res[63-8*i -: 8]);
            hold_ok = 1;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                if (!tx_valid || tx_byte != res[63-8*i -: 8]) hold_ok = 0;
            end
            if (stall > 0)
                check(hold_ok, {"R9 byte held while not ready ", tag}, hold_ok, 1);
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
        end
        check(tx_valid == 0, {"R10 tx ends after eighth byte ", tag}, tx_valid, 0);
        repeat (3) @(negedge clk);
        check(tx_valid == 0 && rx_ack == 0, {"R10 back in idle ", tag},
              {tx_valid, rx_ack}, 0);
    endtask

    initial begin
        t_reset();
        t_idle_quiet();
        t_session(64'h0102_0304_0506_0708, 80'h1112_1314_1516_1718_191A, 0, "ascending");
        t_session(64'hFF00_FF00_FF00_FF00, 80'h00FF_00FF_00FF_00FF_00FF, 3, "alternating");
        t_session(64'hC3A5_1E7B_9D24_F068, 80'h8E4D_2B71_06C9_F53A_17E2, 1, "mixed");
        t_idle_quiet();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end
endmodule